// File: doc/BRIEF.md
# Programmable Time-Slot Crossbar Arbiter

This block decides which of seven agents may drive the master side of a crossbar. It walks a sixteen-entry schedule. Each entry holds a 4-bit class code, and the codes are loaded from two 32-bit schedule words. An agent is granted only while the pointer sits on a slice that carries its code and the agent is requesting. Slices that name an idle agent, the null code or a reserved code are stepped over at one slice per clock. This lets software shape bandwidth: an agent written into more slices wins more often.

A grant is held for as long as its agent keeps requesting. An optional 8-bit hold timer can cut a grant short. The timer is loaded from a preset whenever a grant begins, and an active-low enable input turns it on. When a grant ends, the pointer moves to the slice after the one that was granted. When nobody requests, the arbiter stays where it is.

Top module: `slot_arbiter`

## Requirements
- R1: During and directly after reset, `gnt` is all zeros and `slice_idx` is 0.
- R2: Slice n takes its code from bits [4*(n mod 8)+3 : 4*(n mod 8)] of `sched_lo` when n < 8, and of `sched_hi` when n >= 8.
- R3: Codes map to grant bits as follows: 0→bit 0, 1→bit 1, 3→bit 2, 4→bit 3, 5→bit 4, 6→bit 5, 7→bit 6. `gnt` never has more than one bit set.
- R4: With no grant held, if the current slice names an agent whose `req` bit is 1, that agent's `gnt` bit is set on the next clock and `slice_idx` stays on that slice.
- R5: With no grant held and at least one request present, a slice that names an idle agent, the null code 2, or a reserved code 8–15 produces no grant. `slice_idx` advances by one on the next clock and wraps from 15 to 0.
- R6: While `req` is all zeros and no grant is held, `gnt` stays zero and `slice_idx` holds its value.
- R7: With `tmo_disable` = 1, a grant is kept for as long as the owner's `req` bit stays 1, whatever `tmo_preset` is.
- R8: The clock after the owner's `req` bit is seen low, `gnt` becomes zero and `slice_idx` advances by one.
- R9: With `tmo_disable` = 0, a grant made while `tmo_preset` = P stays visible for exactly P+1 clocks, even with its request held. It then clears and `slice_idx` advances by one.
- R10: A `gnt` bit only ever rises for an agent whose `req` bit was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 7 | Agent request lines, indexed by grant bit |
| sched_lo | input | 32 | Codes for slices 0–7, four bits each |
| sched_hi | input | 32 | Codes for slices 8–15, four bits each |
| tmo_preset | input | 8 | Hold-timer preset, loaded when a grant begins |
| tmo_disable | input | 1 | 1 turns the hold timer off, 0 turns it on |
| gnt | output | 7 | One-hot or zero grant |
| slice_idx | output | 4 | Current schedule slice |

## Verification
The checker watches several properties on every cycle. Grants are at most one-hot. A grant rises only for a requester. The arbiter holds still while idle. A grant persists while its request stays high and the timer is off. A dropped request releases the grant and steps the pointer by exactly one. Other behaviour depends on table contents and on counting cycles, so only the directed scenarios can show it. These scenarios cover the code-to-agent mapping, nibble placement in both schedule words, skipping of null and reserved slots, the 15-to-0 wrap, and the P+1-cycle timer window, including the one-cycle case at preset zero.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    // Class code that names no agent; agents take the codes around it.
    localparam int unsigned IDLE_CODE = 2;

    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_HOLD = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/slot_table_mux.sv
module slot_table_mux #(
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned NUM_SLICES = 2 * REG_W / CODE_W,
    parameter int unsigned SLICE_W    = $clog2(NUM_SLICES)
) (
    input  logic [REG_W-1:0]   sched_lo,
    input  logic [REG_W-1:0]   sched_hi,
    input  logic [SLICE_W-1:0] idx,
    output logic [CODE_W-1:0]  code
);
    localparam int unsigned PER_REG = REG_W / CODE_W;

    logic [CODE_W-1:0] codes [NUM_SLICES];

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        if (s < PER_REG) begin : g_lo
            assign codes[s] = sched_lo[(s % PER_REG)*CODE_W +: CODE_W];
        end else begin : g_hi
            assign codes[s] = sched_hi[(s % PER_REG)*CODE_W +: CODE_W];
        end
    end

    assign code = codes[idx];

endmodule

// File: rtl/slot_code_decode.sv
module slot_code_decode
    import slot_arb_pkg::*;
#(
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned NUM_AGENTS = 7
) (
    input  logic [CODE_W-1:0]     code,
    output logic [NUM_AGENTS-1:0] agent_oh
);
    // Agents below the idle code keep their code as index; those above shift down by one.
    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
        localparam int unsigned ACODE = (a < IDLE_CODE) ? a : a + 1;
        assign agent_oh[a] = (code == CODE_W'(ACODE));
    end

endmodule

// File: rtl/slot_hold_timer.sv
module slot_hold_timer #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [TMO_W-1:0] preset,
    output logic             expired
);
    logic [TMO_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = preset;
        end else if (tick && count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 7,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned TMO_W      = 8,
    localparam int unsigned NUM_SLICES = 2 * REG_W / CODE_W,
    localparam int unsigned SLICE_W    = $clog2(NUM_SLICES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] req,
    input  logic [REG_W-1:0]      sched_lo,
    input  logic [REG_W-1:0]      sched_hi,
    input  logic [TMO_W-1:0]      tmo_preset,
    input  logic                  tmo_disable,
    output logic [NUM_AGENTS-1:0] gnt,
    output logic [SLICE_W-1:0]    slice_idx
);
    localparam logic [SLICE_W-1:0] LAST_SLICE = SLICE_W'(NUM_SLICES - 1);

    typedef struct packed {
        arb_phase_e            phase;
        logic [SLICE_W-1:0]    ptr;
        logic [NUM_AGENTS-1:0] gnt;
    } arb_state_t;

    arb_state_t            st_d, st_q;
    logic [CODE_W-1:0]     slot_code;
    logic [NUM_AGENTS-1:0] slot_oh;
    logic [SLICE_W-1:0]    ptr_next;
    logic                  tmr_load, tmr_tick, tmr_expired;
    logic                  tmr_on, owner_live;

    slot_table_mux #(
        .CODE_W    (CODE_W),
        .REG_W     (REG_W),
        .NUM_SLICES(NUM_SLICES),
        .SLICE_W   (SLICE_W)
    ) i_table (
        .sched_lo(sched_lo),
        .sched_hi(sched_hi),
        .idx     (st_q.ptr),
        .code    (slot_code)
    );

    slot_code_decode #(
        .CODE_W    (CODE_W),
        .NUM_AGENTS(NUM_AGENTS)
    ) i_decode (
        .code    (slot_code),
        .agent_oh(slot_oh)
    );

    slot_hold_timer #(
        .TMO_W(TMO_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .tick   (tmr_tick),
        .preset (tmo_preset),
        .expired(tmr_expired)
    );

    assign tmr_on     = ~tmo_disable;
    assign owner_live = |(st_q.gnt & req);
    assign ptr_next   = (st_q.ptr == LAST_SLICE) ? '0 : st_q.ptr + 1'b1;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        unique case (st_q.phase)
            PH_SCAN: begin
                if (|req) begin
                    if (|(slot_oh & req)) begin
                        st_d.phase = PH_HOLD;
                        st_d.gnt   = slot_oh;
                        tmr_load   = 1'b1;
                    end else begin
                        st_d.ptr = ptr_next;
                    end
                end
            end
            PH_HOLD: begin
                if (!owner_live || (tmr_on && tmr_expired)) begin
                    st_d.phase = PH_SCAN;
                    st_d.gnt   = '0;
                    st_d.ptr   = ptr_next;
                end else begin
                    tmr_tick = tmr_on;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_SCAN, ptr: '0, gnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt       = st_q.gnt;
    assign slice_idx = st_q.ptr;

endmodule

// File: rtl/slot_arbiter_checker.sv
module slot_arbiter_checker #(
    parameter int unsigned NUM_AGENTS = 7,
    parameter int unsigned SLICE_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_AGENTS-1:0] req,
    input logic                  tmo_disable,
    input logic [NUM_AGENTS-1:0] gnt,
    input logic [SLICE_W-1:0]    slice_idx
);
    // R3: at most one grant bit
    a_r3_gnt_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R10: a new grant goes to an agent that was requesting
    a_r10_gnt_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> ((gnt & $past(req)) != '0));

    // R6: idle arbiter keeps pointer and stays ungranted
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && gnt == '0) |=> ($stable(slice_idx) && gnt == '0));

    // R7: timer off and request held keeps the grant
    a_r7_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && tmo_disable && (req & gnt) != '0) |=> $stable(gnt));

    // R8: dropped request releases the grant
    a_r8_release_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (req & gnt) == '0) |=> (gnt == '0));

    // R8: release steps the pointer by exactly one
    a_r8_step_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (req & gnt) == '0) |=>
            (slice_idx == SLICE_W'($past(slice_idx) + 1'b1)));

endmodule

bind slot_arbiter slot_arbiter_checker #(
    .NUM_AGENTS(NUM_AGENTS),
    .SLICE_W   (SLICE_W)
) i_slot_arbiter_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .tmo_disable(tmo_disable),
    .gnt        (gnt),
    .slice_idx  (slice_idx)
);

// File: tb/test_slot_arbiter.sv
`timescale 1ns/1ps
module test_slot_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  req;
    logic [31:0] sched_lo, sched_hi;
    logic [7:0]  tmo_preset;
    logic        tmo_disable;
    logic [6:0]  gnt;
    logic [3:0]  slice_idx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    slot_arbiter i_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req),
        .sched_lo(sched_lo), .sched_hi(sched_hi),
        .tmo_preset(tmo_preset), .tmo_disable(tmo_disable),
        .gnt(gnt), .slice_idx(slice_idx)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 gnt in reset", 32'(gnt), 0);
        chk("R1 slice in reset", 32'(slice_idx), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 gnt after reset", 32'(gnt), 0);
        chk("R1 slice after reset", 32'(slice_idx), 0);
    endtask

    task automatic t_idle(input logic [3:0] where);
        req = '0;
        step(4);
        chk("R6 idle gnt", 32'(gnt), 0);
        chk("R6 idle slice", 32'(slice_idx), 32'(where));
    endtask

    task automatic t_hold();
        tmo_disable = 1'b1; tmo_preset = 8'd0;
        req = 7'b0000100;
        step(1);
        chk("R4 R2 R3 grant code 3 at slice 0", 32'(gnt), 32'h04);
        chk("R4 slice stays", 32'(slice_idx), 0);
        step(5);
        chk("R7 held with timer off", 32'(gnt), 32'h04);
        req = '0;
        step(1);
        chk("R8 gnt cleared", 32'(gnt), 0);
        chk("R8 slice advanced", 32'(slice_idx), 1);
    endtask

    task automatic t_skip();
        req = 7'b0010000;
        step(1);
        chk("R5 null slice skipped", 32'(slice_idx), 2);
        chk("R5 null no grant", 32'(gnt), 0);
        step(1);
        chk("R5 reserved slice skipped", 32'(slice_idx), 3);
        chk("R5 reserved no grant", 32'(gnt), 0);
        step(1);
        chk("R3 R10 code 5 grants bit 4", 32'(gnt), 32'h10);
        req = '0;
        step(1);
        chk("R8 slice after skip test", 32'(slice_idx), 4);
    endtask

    task automatic t_high();
        req = 7'b1000000;
        step(5);
        chk("R5 idle-agent slices skipped", 32'(slice_idx), 9);
        chk("R5 no grant yet", 32'(gnt), 0);
        step(1);
        chk("R2 R3 high word code 7 grants bit 6", 32'(gnt), 32'h40);
        req = '0;
        step(1);
        chk("R8 slice after high test", 32'(slice_idx), 10);
    endtask

    task automatic t_timer();
        tmo_disable = 1'b0; tmo_preset = 8'd3;
        req = 7'b0000011;
        step(1);
        chk("R3 code 0 grants bit 0", 32'(gnt), 32'h01);
        step(3);
        chk("R9 still granted in 4th cycle", 32'(gnt), 32'h01);
        tmo_preset = 8'd0;
        step(1);
        chk("R9 expiry clears grant", 32'(gnt), 0);
        chk("R9 expiry advances slice", 32'(slice_idx), 11);
        step(1);
        chk("R3 code 1 grants bit 1", 32'(gnt), 32'h02);
        step(1);
        chk("R9 preset 0 gives one cycle", 32'(gnt), 0);
        chk("R9 slice after one-cycle grant", 32'(slice_idx), 12);
        req = '0;
        tmo_disable = 1'b1;
    endtask

    task automatic t_wrap();
        req = 7'b0000100;
        step(3);
        chk("R5 reached slice 15", 32'(slice_idx), 15);
        step(1);
        chk("R5 wrap to 0", 32'(slice_idx), 0);
        chk("R5 no grant at wrap", 32'(gnt), 0);
        step(1);
        chk("R4 grant after wrap", 32'(gnt), 32'h04);
        req = '0;
        step(1);
        chk("R8 slice after wrap test", 32'(slice_idx), 1);
    endtask

    initial begin
        rst_n       = 1'b0;
        req         = '0;
        // slices 0..7: 3, 2, F, 5, 2, 2, 2, 2
        sched_lo    = 32'h2222_5F23;
        // slices 8..15: 2, 7, 0, 1, 2, 2, 2, 2
        sched_hi    = 32'h2222_1072;
        tmo_preset  = 8'd0;
        tmo_disable = 1'b1;
        step(3);
        t_reset();
        t_idle(4'd0);
        t_hold();
        t_skip();
        t_high();
        t_timer();
        t_wrap();
        t_idle(4'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule